// File: doc/BRIEF.md
# Descriptor ring index controller

This block keeps the slot indices for a transmit ring and a receive ring of descriptors that software and a DMA engine share in memory. Each ring has a size register, a producer index and a consumer index. Both indices wrap at the programmed ring size. For transmit, software produces by writing the producer index, and a completion pulse from the engine advances the consumer index. For receive, a fill pulse from the engine advances the producer index, and software hands slots back by writing the consumer index. Whether a ring is empty or full is decided only by comparing its two indices. When either index is equal to the ring count it wraps to zero on its next step.

Register map (3-bit address, 32-bit data): 0 control (bit 0 enables the transmit ring, bit 1 the receive ring), 1 transmit count-minus-one, 2 transmit producer, 3 transmit consumer (read-only), 4 receive count-minus-one, 5 receive producer (read-only), 6 receive consumer, 7 done flags (bit 0 transmit, bit 1 receive, write 1 to clear). Reads are combinational from a separate read address.

The block also builds and decodes the per-slot words, using a 32-bit layout. All length fields in this layout hold the byte count minus one in bits [10:0].

Top module: `ring_index_ctrl`

## Requirements
- R1: After reset the control and done-flag registers read 0, both count registers read 3, all four indices read 0, both rings report empty and not full.
- R2: A count register holds ring entries minus one. A write to it takes effect only while that ring is disabled and the value is non-zero with no bit set above the index width; otherwise it is ignored.
- R3: Every index step goes from the count value back to 0, otherwise up by one, so indices never exceed the count.
- R4: A software write to the transmit producer (address 2) or receive consumer (address 6) is ignored when the value exceeds the ring count; writes to addresses 3 and 5 change nothing.
- R5: A ring is empty when producer equals consumer, and full when the producer's next step would equal the consumer, so one slot stays unused.
- R6: A transmit completion pulse on an enabled, non-empty ring advances the transmit consumer by one step; on an empty ring it is ignored.
- R7: A receive fill pulse on an enabled, non-full ring advances the receive producer by one step; on a full ring it is ignored.
- R8: Each accepted pulse sets its ring's done flag (bit 0 transmit, bit 1 receive); writing 1 to a flag clears it, and a set in the same cycle wins over the clear.
- R9: While a ring is disabled its two indices are held at 0 and software index writes to it are ignored.
- R10: The transmit descriptor word carries frame length minus one in bits [10:0], the last-fragment flag at bit 30, and zeros elsewhere.
- R11: The receive descriptor word carries buffer size minus one in bits [10:0], the interrupt-request flag at bit 31, and zeros in bits [30:11].
- R12: From a receive status word the block returns the length as bits [10:0] plus one, and flags the slot good when none of the bits in mask 0x1B800000 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| tx_done_i | input | 1 | Engine finished one transmit slot |
| rx_fill_i | input | 1 | Engine filled one receive slot |
| tx_empty_o | output | 1 | Transmit ring empty |
| tx_full_o | output | 1 | Transmit ring full |
| rx_empty_o | output | 1 | Receive ring empty |
| rx_full_o | output | 1 | Receive ring full |
| tx_irq_o | output | 1 | Transmit done flag |
| rx_irq_o | output | 1 | Receive done flag |
| tx_len_i | input | 12 | Transmit frame length in bytes (1..2048) |
| tx_last_i | input | 1 | Last-fragment flag |
| tx_desc_o | output | 32 | Formatted transmit descriptor word |
| rx_buf_len_i | input | 12 | Receive buffer size in bytes (1..2048) |
| rx_irq_req_i | input | 1 | Interrupt request flag for the slot |
| rx_desc_o | output | 32 | Formatted receive descriptor word |
| rx_stat_i | input | 32 | Raw receive status word |
| rx_len_o | output | 12 | Decoded received length in bytes |
| rx_good_o | output | 1 | No error bit set in the status word |

## Verification
Register writes, completion and fill pulses all take effect on the next rising edge. The indices, the empty and full flags and the done flags therefore change one edge after the stimulus, and the descriptor and status words follow their inputs in the same cycle. The bench drives each stimulus just after a falling edge and keeps its reference state one edge behind. It compares flags and reads back every register after the following falling edge, once the update edge has passed. It checks the format words a few time units after it changes their inputs, within that same low phase.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      A_CTRL   = 3'd0,
      A_TXCNT  = 3'd1,
      A_TXPROD = 3'd2,
      A_TXCONS = 3'd3,
      A_RXCNT  = 3'd4,
      A_RXPROD = 3'd5,
      A_RXCONS = 3'd6,
      A_IRQ    = 3'd7
   } ring_reg_e;

   localparam int TX_RING  = 0;
   localparam int RX_RING  = 1;
   localparam int RING_NUM = 2;

   localparam int WORD_W      = 32;
   localparam int TX_LAST_BIT = 30;
   localparam int RX_IRQ_BIT  = 31;
   localparam logic [WORD_W-1:0] RX_ERR_MASK = 32'h1B80_0000;

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
   parameter int          IDX_W        = 8,
   parameter int unsigned RST_CNT_M1   = 3,
   parameter bit          HW_OWNS_PROD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cnt_we,
   input  logic [IDX_W-1:0] cnt_wval,
   input  logic             idx_we,
   input  logic [IDX_W-1:0] idx_wval,
   input  logic             hw_step,
   output logic [IDX_W-1:0] cnt_q,
   output logic [IDX_W-1:0] prod_q,
   output logic [IDX_W-1:0] cons_q,
   output logic             empty,
   output logic             full,
   output logic             step_taken
);

   localparam logic [IDX_W-1:0] RST_CNT = IDX_W'(RST_CNT_M1);

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_w
      $error("ring_ptr: IDX_W out of range");
   end
   if (RST_CNT_M1 < 1 || RST_CNT_M1 >= (1 << IDX_W)) begin : g_bad_cnt
      $error("ring_ptr: reset count must be 1..2**IDX_W-1");
   end

   logic [IDX_W-1:0] prod_inc, cons_inc;
   logic             cnt_take, idx_take;

   always_comb begin
      prod_inc = (prod_q == cnt_q) ? '0 : prod_q + 1'b1;
      cons_inc = (cons_q == cnt_q) ? '0 : cons_q + 1'b1;
      empty    = (prod_q == cons_q);
      full     = (prod_inc == cons_q);
      cnt_take = cnt_we && !en && (cnt_wval != '0);
      idx_take = idx_we && en && (idx_wval <= cnt_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= RST_CNT;
      else if (cnt_take) cnt_q <= cnt_wval;
   end

   if (HW_OWNS_PROD) begin : g_hw_prod
      assign step_taken = hw_step && en && !full;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
            cons_q <= '0;
         end else if (!en) begin
            prod_q <= '0;
            cons_q <= '0;
         end else begin
            if (step_taken) prod_q <= prod_inc;
            if (idx_take)   cons_q <= idx_wval;
         end
      end
   end else begin : g_hw_cons
      assign step_taken = hw_step && en && !empty;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
            cons_q <= '0;
         end else if (!en) begin
            prod_q <= '0;
            cons_q <= '0;
         end else begin
            if (idx_take)   prod_q <= idx_wval;
            if (step_taken) cons_q <= cons_inc;
         end
      end
   end

endmodule

// File: rtl/ring_word_fmt.sv
module ring_word_fmt
   import ring_idx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 11
) (
   input  logic [LEN_W:0]    tx_len_i,
   input  logic              tx_last_i,
   input  logic [LEN_W:0]    rx_buf_len_i,
   input  logic              rx_irq_req_i,
   input  logic [DATA_W-1:0] rx_stat_i,
   output logic [DATA_W-1:0] tx_desc_o,
   output logic [DATA_W-1:0] rx_desc_o,
   output logic [LEN_W:0]    rx_len_o,
   output logic              rx_good_o
);

   localparam logic [DATA_W-1:0] LEN_MASK = {{(DATA_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};

   if (DATA_W != WORD_W) begin : g_bad_dw
      $error("ring_word_fmt: flag bit positions need a 32-bit word");
   end
   if (LEN_W < 1 || LEN_W > 29) begin : g_bad_lw
      $error("ring_word_fmt: LEN_W would overlap the flag bits");
   end

   always_comb begin
      tx_desc_o              = (DATA_W'(tx_len_i) - DATA_W'(1)) & LEN_MASK;
      tx_desc_o[TX_LAST_BIT] = tx_last_i;

      rx_desc_o              = (DATA_W'(rx_buf_len_i) - DATA_W'(1)) & LEN_MASK;
      rx_desc_o[RX_IRQ_BIT]  = rx_irq_req_i;

      rx_len_o  = (LEN_W+1)'(rx_stat_i & LEN_MASK) + 1'b1;
      rx_good_o = ((rx_stat_i & RX_ERR_MASK) == '0);
   end

endmodule

// File: rtl/ring_index_ctrl.sv
module ring_index_ctrl
   import ring_idx_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          IDX_W      = 8,
   parameter int          LEN_W      = 11,
   parameter int unsigned TX_CNT_RST = 3,
   parameter int unsigned RX_CNT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_done_i,
   input  logic              rx_fill_i,
   output logic              tx_empty_o,
   output logic              tx_full_o,
   output logic              rx_empty_o,
   output logic              rx_full_o,
   output logic              tx_irq_o,
   output logic              rx_irq_o,
   input  logic [LEN_W:0]    tx_len_i,
   input  logic              tx_last_i,
   output logic [DATA_W-1:0] tx_desc_o,
   input  logic [LEN_W:0]    rx_buf_len_i,
   input  logic              rx_irq_req_i,
   output logic [DATA_W-1:0] rx_desc_o,
   input  logic [DATA_W-1:0] rx_stat_i,
   output logic [LEN_W:0]    rx_len_o,
   output logic              rx_good_o
);

   localparam int PAD_W = DATA_W - IDX_W;

   if (IDX_W >= DATA_W) begin : g_bad_idx
      $error("ring_index_ctrl: IDX_W must be narrower than DATA_W");
   end

   logic [RING_NUM-1:0]            ctrl_q;
   logic [RING_NUM-1:0]            irq_q;
   logic [RING_NUM-1:0][IDX_W-1:0] cnt_a, prod_a, cons_a;
   logic [RING_NUM-1:0]            empty_a, full_a, take_a, steps;
   logic                           hi_zero;

   assign hi_zero = ((reg_wdata >> IDX_W) == '0);
   assign steps   = {rx_fill_i, tx_done_i};

   for (genvar g = 0; g < RING_NUM; g++) begin : g_ring
      localparam logic [2:0] CNT_ADDR = (g == RX_RING) ? 3'(A_RXCNT)  : 3'(A_TXCNT);
      localparam logic [2:0] SW_ADDR  = (g == RX_RING) ? 3'(A_RXCONS) : 3'(A_TXPROD);

      ring_ptr #(
         .IDX_W       (IDX_W),
         .RST_CNT_M1  ((g == RX_RING) ? RX_CNT_RST : TX_CNT_RST),
         .HW_OWNS_PROD(g == RX_RING)
      ) u_ring (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (ctrl_q[g]),
         .cnt_we    (reg_wr && (reg_waddr == CNT_ADDR) && hi_zero),
         .cnt_wval  (reg_wdata[IDX_W-1:0]),
         .idx_we    (reg_wr && (reg_waddr == SW_ADDR) && hi_zero),
         .idx_wval  (reg_wdata[IDX_W-1:0]),
         .hw_step   (steps[g]),
         .cnt_q     (cnt_a[g]),
         .prod_q    (prod_a[g]),
         .cons_q    (cons_a[g]),
         .empty     (empty_a[g]),
         .full      (full_a[g]),
         .step_taken(take_a[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         irq_q  <= '0;
      end else begin
         if (reg_wr && (reg_waddr == A_CTRL)) ctrl_q <= reg_wdata[RING_NUM-1:0];
         if (reg_wr && (reg_waddr == A_IRQ))
            irq_q <= (irq_q & ~reg_wdata[RING_NUM-1:0]) | take_a;
         else
            irq_q <= irq_q | take_a;
      end
   end

   always_comb begin
      unique case (reg_raddr)
         A_CTRL:   reg_rdata = {{(DATA_W-RING_NUM){1'b0}}, ctrl_q};
         A_TXCNT:  reg_rdata = {{PAD_W{1'b0}}, cnt_a[TX_RING]};
         A_TXPROD: reg_rdata = {{PAD_W{1'b0}}, prod_a[TX_RING]};
         A_TXCONS: reg_rdata = {{PAD_W{1'b0}}, cons_a[TX_RING]};
         A_RXCNT:  reg_rdata = {{PAD_W{1'b0}}, cnt_a[RX_RING]};
         A_RXPROD: reg_rdata = {{PAD_W{1'b0}}, prod_a[RX_RING]};
         A_RXCONS: reg_rdata = {{PAD_W{1'b0}}, cons_a[RX_RING]};
         default:  reg_rdata = {{(DATA_W-RING_NUM){1'b0}}, irq_q};
      endcase
   end

   assign tx_empty_o = empty_a[TX_RING];
   assign tx_full_o  = full_a[TX_RING];
   assign rx_empty_o = empty_a[RX_RING];
   assign rx_full_o  = full_a[RX_RING];
   assign tx_irq_o   = irq_q[TX_RING];
   assign rx_irq_o   = irq_q[RX_RING];

   ring_word_fmt #(
      .DATA_W(DATA_W),
      .LEN_W (LEN_W)
   ) u_fmt (
      .tx_len_i    (tx_len_i),
      .tx_last_i   (tx_last_i),
      .rx_buf_len_i(rx_buf_len_i),
      .rx_irq_req_i(rx_irq_req_i),
      .rx_stat_i   (rx_stat_i),
      .tx_desc_o   (tx_desc_o),
      .rx_desc_o   (rx_desc_o),
      .rx_len_o    (rx_len_o),
      .rx_good_o   (rx_good_o)
   );

endmodule

// File: rtl/ring_index_ctrl_chk.sv
module ring_index_ctrl_chk #(
   parameter int IDX_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            en,
   input logic                  tx_done_i,
   input logic                  rx_fill_i,
   input logic [1:0][IDX_W-1:0] cnt,
   input logic [1:0][IDX_W-1:0] prod,
   input logic [1:0][IDX_W-1:0] cons,
   input logic                  tx_empty_o,
   input logic                  tx_full_o,
   input logic                  rx_empty_o,
   input logic                  rx_full_o,
   input logic                  tx_irq_o
);

   // R9
   tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[0] |=> (prod[0] == '0 && cons[0] == '0));

   // R9
   rx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[1] |=> (prod[1] == '0 && cons[1] == '0));

   // R5
   tx_not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_empty_o && tx_full_o));

   // R5
   rx_not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty_o && rx_full_o));

   // R3
   idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prod[0] <= cnt[0]) && (cons[0] <= cnt[0]) &&
      (prod[1] <= cnt[1]) && (cons[1] <= cnt[1]));

   // R2
   cnt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[0] |=> $stable(cnt[0]));

   // R6
   tx_cons_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[0] && !tx_done_i) |=> $stable(cons[0]));

   // R6
   tx_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[0] && tx_done_i && !tx_empty_o) |=> tx_irq_o);

   // R7
   rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[1] && rx_full_o) |=> $stable(prod[1]));

endmodule

bind ring_index_ctrl ring_index_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (ctrl_q),
   .tx_done_i (tx_done_i),
   .rx_fill_i (rx_fill_i),
   .cnt       (cnt_a),
   .prod      (prod_a),
   .cons      (cons_a),
   .tx_empty_o(tx_empty_o),
   .tx_full_o (tx_full_o),
   .rx_empty_o(rx_empty_o),
   .rx_full_o (rx_full_o),
   .tx_irq_o  (tx_irq_o)
);

// File: tb/ring_index_ctrl_tb.sv
module ring_index_ctrl_tb;
   import ring_idx_pkg::*;

   localparam int CLK_PERIOD = 40;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 8;
   localparam int LEN_W  = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [2:0]        reg_waddr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [2:0]        reg_raddr = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              tx_done_i = 1'b0, rx_fill_i = 1'b0;
   logic              tx_empty_o, tx_full_o, rx_empty_o, rx_full_o, tx_irq_o, rx_irq_o;
   logic [LEN_W:0]    tx_len_i = 12'd1, rx_buf_len_i = 12'd1;
   logic              tx_last_i = 1'b0, rx_irq_req_i = 1'b0;
   logic [DATA_W-1:0] tx_desc_o, rx_desc_o, rx_stat_i = '0;
   logic [LEN_W:0]    rx_len_o;
   logic              rx_good_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_index_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .tx_done_i(tx_done_i), .rx_fill_i(rx_fill_i),
      .tx_empty_o(tx_empty_o), .tx_full_o(tx_full_o),
      .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o),
      .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
      .tx_len_i(tx_len_i), .tx_last_i(tx_last_i), .tx_desc_o(tx_desc_o),
      .rx_buf_len_i(rx_buf_len_i), .rx_irq_req_i(rx_irq_req_i), .rx_desc_o(rx_desc_o),
      .rx_stat_i(rx_stat_i), .rx_len_o(rx_len_o), .rx_good_o(rx_good_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [1:0]       m_en, m_irq;
   logic [IDX_W-1:0] m_cnt [2];
   logic [IDX_W-1:0] m_prod[2];
   logic [IDX_W-1:0] m_cons[2];

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   function automatic logic [IDX_W-1:0] m_nx(input int g, input logic [IDX_W-1:0] i);
      return (i == m_cnt[g]) ? '0 : i + 1'b1;
   endfunction

   function automatic logic m_full(input int g);
      return m_nx(g, m_prod[g]) == m_cons[g];
   endfunction

   function automatic logic [31:0] exp_rd(input int a);
      case (a)
         0: return {30'd0, m_en};
         1: return 32'(m_cnt[0]);
         2: return 32'(m_prod[0]);
         3: return 32'(m_cons[0]);
         4: return 32'(m_cnt[1]);
         5: return 32'(m_prod[1]);
         6: return 32'(m_cons[1]);
         default: return {30'd0, m_irq};
      endcase
   endfunction

   function automatic string rd_tag(input int a);
      if (a == 0 || a == 7) return "R8";
      if (a == 1 || a == 4) return "R2";
      return "R3";
   endfunction

   task automatic model_reset();
      m_en = '0; m_irq = '0;
      for (int g = 0; g < 2; g++) begin
         m_cnt[g] = 8'd3; m_prod[g] = '0; m_cons[g] = '0;
      end
   endtask

   task automatic model_step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                             input logic td, input logic rf);
      logic [1:0] acc;
      logic hz;
      logic [IDX_W-1:0] np[2], nc[2], nn[2];
      hz = (d >> IDX_W) == 0;
      acc[0] = td && m_en[0] && (m_prod[0] != m_cons[0]);
      acc[1] = rf && m_en[1] && !m_full(1);
      for (int g = 0; g < 2; g++) begin
         np[g] = m_prod[g]; nc[g] = m_cons[g]; nn[g] = m_cnt[g];
      end
      if (!m_en[0]) begin np[0] = '0; nc[0] = '0; end
      else begin
         if (wr && a == 3'd2 && hz && d <= 32'(m_cnt[0])) np[0] = d[IDX_W-1:0];
         if (acc[0]) nc[0] = m_nx(0, m_cons[0]);
      end
      if (!m_en[1]) begin np[1] = '0; nc[1] = '0; end
      else begin
         if (acc[1]) np[1] = m_nx(1, m_prod[1]);
         if (wr && a == 3'd6 && hz && d <= 32'(m_cnt[1])) nc[1] = d[IDX_W-1:0];
      end
      if (wr && a == 3'd1 && !m_en[0] && hz && d != 0) nn[0] = d[IDX_W-1:0];
      if (wr && a == 3'd4 && !m_en[1] && hz && d != 0) nn[1] = d[IDX_W-1:0];
      m_irq = (m_irq & ~((wr && a == 3'd7) ? d[1:0] : 2'b00)) | acc;
      if (wr && a == 3'd0) m_en = d[1:0];
      for (int g = 0; g < 2; g++) begin
         m_prod[g] = np[g]; m_cons[g] = nc[g]; m_cnt[g] = nn[g];
      end
   endtask

   task automatic fmt_check();
      logic [31:0] e;
      logic [31:0] st;
      tx_len_i     = 12'(1 + ($urandom % 2048));
      tx_last_i    = 1'($urandom);
      rx_buf_len_i = 12'(1 + ($urandom % 2048));
      rx_irq_req_i = 1'($urandom);
      st = $urandom;
      if ($urandom % 2 == 0) st = st & ~32'h1B80_0000;
      rx_stat_i = st;
      #1;
      e = ((32'(tx_len_i) - 1) & 32'h7FF) | (32'(tx_last_i) << 30);
      chk("R10", "tx descriptor word", tx_desc_o, e);
      e = ((32'(rx_buf_len_i) - 1) & 32'h7FF) | (32'(rx_irq_req_i) << 31);
      chk("R11", "rx descriptor word", rx_desc_o, e);
      chk("R12", "rx length", 32'(rx_len_o), (st & 32'h7FF) + 1);
      chk("R12", "rx good", 32'(rx_good_o), 32'((st & 32'h1B80_0000) == 0));
   endtask

   task automatic compare_all();
      chk("R5", "tx empty", 32'(tx_empty_o), 32'(m_prod[0] == m_cons[0]));
      chk("R5", "tx full",  32'(tx_full_o),  32'(m_full(0)));
      chk("R5", "rx empty", 32'(rx_empty_o), 32'(m_prod[1] == m_cons[1]));
      chk("R5", "rx full",  32'(rx_full_o),  32'(m_full(1)));
      chk("R8", "tx flag",  32'(tx_irq_o),   32'(m_irq[0]));
      chk("R8", "rx flag",  32'(rx_irq_o),   32'(m_irq[1]));
      for (int a = 0; a < 8; a++) begin
         reg_raddr = 3'(a);
         #1;
         chk(rd_tag(a), $sformatf("read addr %0d", a), reg_rdata, exp_rd(a));
      end
      fmt_check();
   endtask

   task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      input logic td, input logic rf);
      reg_wr = wr; reg_waddr = a; reg_wdata = d; tx_done_i = td; rx_fill_i = rf;
      @(posedge clk);
      model_step(wr, a, d, td, rf);
      @(negedge clk);
      reg_wr = 1'b0; tx_done_i = 1'b0; rx_fill_i = 1'b0;
      compare_all();
   endtask

   task automatic rd_chk(input string tag, input string what, input int a, input logic [31:0] exp);
      reg_raddr = 3'(a);
      #1;
      chk(tag, what, reg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset values through the register port and flags
      for (int a = 0; a < 8; a++) rd_chk("R1", $sformatf("reset addr %0d", a), a, exp_rd(a));
      chk("R1", "reset tx empty", 32'(tx_empty_o), 1);
      chk("R1", "reset rx full", 32'(rx_full_o), 0);
      @(negedge clk);

      // R2: zero and oversize counts ignored, locked while enabled
      cyc(1, 3'd1, 32'd0, 0, 0);
      rd_chk("R2", "zero count ignored", 1, 3);
      cyc(1, 3'd1, 32'h100, 0, 0);
      rd_chk("R2", "oversize count ignored", 1, 3);
      cyc(1, 3'd0, 32'd3, 0, 0);
      cyc(1, 3'd1, 32'd7, 0, 0);
      rd_chk("R2", "count locked while enabled", 1, 3);

      // R9 precheck: tx producer path, fill to full (R5)
      cyc(1, 3'd2, 32'd1, 0, 0);
      cyc(1, 3'd2, 32'd2, 0, 0);
      cyc(1, 3'd2, 32'd3, 0, 0);
      chk("R5", "tx full at 3 of 4", 32'(tx_full_o), 1);
      // R4: out of range and read-only writes
      cyc(1, 3'd2, 32'd4, 0, 0);
      rd_chk("R4", "tx prod oversize ignored", 2, 3);
      cyc(1, 3'd3, 32'd2, 0, 0);
      rd_chk("R4", "tx cons read-only", 3, 0);
      // R6: completions advance consumer
      cyc(0, 3'd0, 0, 1, 0);
      rd_chk("R6", "tx cons after one done", 3, 1);
      chk("R8", "tx flag set", 32'(tx_irq_o), 1);
      cyc(0, 3'd0, 0, 1, 0);
      cyc(0, 3'd0, 0, 1, 0);
      chk("R6", "tx empty after drain", 32'(tx_empty_o), 1);
      cyc(1, 3'd7, 32'd1, 0, 0);
      chk("R8", "tx flag cleared", 32'(tx_irq_o), 0);
      cyc(0, 3'd0, 0, 1, 0);
      rd_chk("R6", "done on empty ignored", 3, 3);
      chk("R6", "no flag on empty", 32'(tx_irq_o), 0);
      // R3: wrap from count to zero
      cyc(1, 3'd2, 32'd0, 0, 0);
      cyc(0, 3'd0, 0, 1, 0);
      rd_chk("R3", "tx cons wraps", 3, 0);

      // R7: receive fill to full then ignored
      cyc(0, 3'd0, 0, 0, 1);
      cyc(0, 3'd0, 0, 0, 1);
      cyc(0, 3'd0, 0, 0, 1);
      chk("R7", "rx full", 32'(rx_full_o), 1);
      cyc(0, 3'd0, 0, 0, 1);
      rd_chk("R7", "fill on full ignored", 5, 3);
      cyc(1, 3'd7, 32'd2, 0, 0);
      cyc(1, 3'd6, 32'd9, 0, 0);
      rd_chk("R4", "rx cons oversize ignored", 6, 0);
      cyc(1, 3'd6, 32'd1, 0, 0);
      chk("R7", "rx not full after return", 32'(rx_full_o), 0);
      // R8: set wins over clear
      cyc(1, 3'd7, 32'd2, 0, 1);
      chk("R8", "set beats clear", 32'(rx_irq_o), 1);

      // R9: disable zeroes indices and blocks writes
      cyc(1, 3'd0, 32'd0, 0, 0);
      rd_chk("R9", "rx prod zero when off", 5, 0);
      cyc(1, 3'd2, 32'd2, 0, 0);
      rd_chk("R9", "tx write ignored when off", 2, 0);

      // R10 R11 R12 directed corners
      tx_len_i = 12'd2048; tx_last_i = 1'b1; rx_buf_len_i = 12'd1; rx_irq_req_i = 1'b1;
      rx_stat_i = 32'h4000_07FF;
      #1;
      chk("R10", "max length last", tx_desc_o, 32'h4000_07FF);
      chk("R11", "min size irq", rx_desc_o, 32'h8000_0000);
      chk("R12", "range bit not an error", 32'(rx_good_o), 1);
      chk("R12", "max length", 32'(rx_len_o), 2048);
      rx_stat_i = 32'h0080_0000;
      #1;
      chk("R12", "error bit 23", 32'(rx_good_o), 0);
      @(negedge clk);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [2:0] a;
         logic [31:0] d;
         r = $urandom % 16;
         a = 3'd0; d = 0;
         case (r)
            0: begin a = 3'd0; d = ($urandom % 4 == 0) ? 32'($urandom % 4) : 32'd3; end
            1: begin a = 3'd1; d = 32'($urandom % 10); end
            2: begin a = 3'd4; d = 32'($urandom % 10); end
            3, 4: begin a = 3'd2; d = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 12); end
            5, 6: begin a = 3'd6; d = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 12); end
            7: begin a = 3'd7; d = 32'($urandom % 4); end
            8: begin a = ($urandom % 2) ? 3'd3 : 3'd5; d = 32'($urandom % 8); end
            default: ;
         endcase
         cyc(r <= 8, a, d, 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule